// File: doc/BRIEF.md
# Programmable Time-Slice Crossbar Arbiter

This block hands a shared CPU-side path to one of eight requesting units. The order of service comes from a sixteen-entry slot table that software writes as two 32-bit words. Each entry is a 4-bit owner code. A pointer walks the table in a circle. At each arbitration it stops at the next entry whose owner is requesting, and that owner receives a one-hot grant. Entries holding the null code or a reserved code are passed over.

A grant stays with its owner for as long as the owner keeps its request up. When the hold timer is enabled, the grant also ends once an 8-bit preset count has run out, and arbitration then moves on. A unit that is written into more table entries receives a larger share of the path. Only the grant decision is built here. The data path and each requester's own protocol belong to other blocks.

Top module: `slice_arbiter`

## Requirements
- R1: After reset `gnt` is all zero and `gnt_slot` is 0.
- R2: Table entry n (0 to 15) is the 4-bit field at bits 4*(n%8)+3 down to 4*(n%8). Entries 0 to 7 are taken from `slots_lo` and entries 8 to 15 from `slots_hi`.
- R3: An owner code c in 0..7 other than 2 names unit c. When that entry is chosen, `gnt` has bit c set and no other bit, and `gnt_slot` holds the entry index.
- R4: Code 2 (null) and codes 8 to 15 (reserved) are never granted. Their entries are skipped even while every request line is high.
- R5: The search for a new owner starts at the entry after `gnt_slot`, wraps from 15 to 0, and examines the current entry last. Right after reset the first entry examined is 1.
- R6: A grant is registered. It appears in the cycle after the clock edge at which the request was seen, and it follows the R5 order on every cycle.
- R7: An active grant does not change until its owner drops its request or the timer expires. At that same edge a new search is made, so grants can follow one another with no idle cycle.
- R8: Bit 16 of `tmo_cfg` at 0 enables the timer. The preset is bits 7:0. A grant is then held for at most preset+1 cycles before the next search.
- R9: With bit 16 of `tmo_cfg` at 1, a grant has no time limit.
- R10: When no table entry names a requesting unit, `gnt` becomes zero and `gnt_slot` keeps its value.
- R11: With every unit requesting and a preset of 0, each unit's share of grant cycles equals its share of table entries.
- R12: At most one bit of `gnt` is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 8 | Request line per unit, indexed by owner code |
| slots_lo | input | 32 | Owner codes for table entries 0 to 7 |
| slots_hi | input | 32 | Owner codes for table entries 8 to 15 |
| tmo_cfg | input | 32 | Bits 7:0 hold-time preset; bit 16 timer disable (1 = off) |
| gnt | output | 8 | One-hot grant |
| gnt_slot | output | 4 | Table entry of the latest grant |

## Verification
The hold-time assertion assumes that `tmo_cfg` stays constant while a grant is active. Every assertion also assumes that table changes land only while the block is idle. To keep to this, the stimulus changes the table and the timer word only after it has held every request low for two cycles. Request lines themselves change freely from cycle to cycle, and a behavioural model of slot selection runs alongside the block. The random phase draws owner codes that include null and reserved values, which exercises the skip logic.

// File: rtl/slice_arbiter.sv
module slice_arbiter #(
  parameter int UNITS     = 8,
  parameter int SLOTS     = 16,
  parameter int CODE_W    = 4,
  parameter int TMO_W     = 8,
  parameter int TMO_OFF   = 16,
  parameter int NULL_CODE = 2,
  localparam int PTR_W = $clog2(SLOTS),
  localparam int UID_W = $clog2(UNITS),
  localparam int TBL_W = SLOTS * CODE_W,
  localparam int HALF  = TBL_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [UNITS-1:0] req,
  input  logic [HALF-1:0]  slots_lo,
  input  logic [HALF-1:0]  slots_hi,
  input  logic [31:0]      tmo_cfg,
  output logic [UNITS-1:0] gnt,
  output logic [PTR_W-1:0] gnt_slot
);

  logic [TBL_W-1:0]  tbl;
  logic [CODE_W-1:0] code [SLOTS];
  logic [SLOTS-1:0]  elig;
  logic [PTR_W-1:0]  ptr, pick, idx;
  logic [UID_W-1:0]  own;
  logic [TMO_W-1:0]  tmr, preset;
  logic              busy, hit, tmo_on, release_g, arb;

  assign tbl    = {slots_hi, slots_lo};
  assign preset = tmo_cfg[TMO_W-1:0];
  assign tmo_on = !tmo_cfg[TMO_OFF];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign code[g] = tbl[g*CODE_W +: CODE_W];
    assign elig[g] = (code[g] < CODE_W'(UNITS)) && (code[g] != CODE_W'(NULL_CODE))
                     && req[code[g][UID_W-1:0]];
  end

  always_comb begin
    hit  = 1'b0;
    pick = ptr;
    idx  = ptr;
    for (int k = 1; k <= SLOTS; k++) begin
      idx = ptr + PTR_W'(k);
      if (!hit && elig[idx]) begin
        hit  = 1'b1;
        pick = idx;
      end
    end
  end

  assign release_g = busy && (!req[own] || (tmo_on && tmr == '0));
  assign arb       = !busy || release_g;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr  <= '0;
      own  <= '0;
      busy <= 1'b0;
      tmr  <= '0;
    end else if (arb) begin
      if (hit) begin
        ptr  <= pick;
        own  <= code[pick][UID_W-1:0];
        busy <= 1'b1;
        tmr  <= preset;
      end else begin
        busy <= 1'b0;
      end
    end else if (tmr != '0) begin
      tmr <= tmr - 1'b1;
    end
  end

  assign gnt      = busy ? (UNITS'(1) << own) : '0;
  assign gnt_slot = ptr;

  logic [TMO_W:0] held;
  always_ff @(posedge clk) begin
    if (!rst_n)             held <= '0;
    else if (arb && hit)    held <= '0;
    else if (busy && !(&held)) held <= held + 1'b1;
  end

  assert_grant_had_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |-> ((gnt & $past(req)) != '0));

  assert_idle_when_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> (gnt == '0));

  assert_grant_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !release_g) |=> ($stable(gnt) && $stable(gnt_slot)));

  assert_hold_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tmo_on) |-> (held <= {1'b0, preset}));

  assert_single_grant_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

endmodule

// File: tb/sim_slice_arbiter.sv
`timescale 1ns/1ps
module sim_slice_arbiter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  req = '0;
  logic [31:0] slots_lo = 32'h2222_2222;
  logic [31:0] slots_hi = 32'h2222_2222;
  logic [31:0] tmo_cfg = 32'h0001_0000;
  logic [7:0]  gnt;
  logic [3:0]  gnt_slot;

  int checks = 0, fails = 0;
  int mptr = 0, mown = 0, mtmr = 0;
  bit mbusy = 0;
  bit cmp_on = 0;
  bit done = 0;

  always #10 clk = ~clk;

  slice_arbiter u0 (.clk(clk), .rst_n(rst_n), .req(req), .slots_lo(slots_lo),
    .slots_hi(slots_hi), .tmo_cfg(tmo_cfg), .gnt(gnt), .gnt_slot(gnt_slot));

  function automatic int slot_code(int s);
    if (s < 8) return int'((slots_lo >> (4*s)) & 32'hF);
    return int'((slots_hi >> (4*(s-8))) & 32'hF);
  endfunction

  function automatic int find_slot(int p);
    for (int k = 1; k <= 16; k++) begin
      int s, c;
      s = (p + k) % 16;
      c = slot_code(s);
      if (c < 8 && c != 2 && req[c]) return s;
    end
    return -1;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference of slot selection (R5, R7, R8)
  always @(posedge clk) begin
    int s;
    bit rel;
    if (!rst_n) begin
      mptr = 0; mown = 0; mtmr = 0; mbusy = 0;
    end else begin
      rel = mbusy && (!req[mown] || (!tmo_cfg[16] && mtmr == 0));
      if (!mbusy || rel) begin
        s = find_slot(mptr);
        if (s >= 0) begin
          mptr = s; mown = slot_code(s); mbusy = 1; mtmr = int'(tmo_cfg[7:0]);
        end else mbusy = 0;
      end else if (mtmr > 0) mtmr--;
    end
  end

  // Per-cycle comparison (R6, R12)
  always @(negedge clk) if (cmp_on) begin
    int eg;
    eg = mbusy ? (1 << mown) : 0;
    check(gnt == 8'(eg), "R6 grant", gnt, eg);
    check(gnt_slot == 4'(mptr), "R6 slot", gnt_slot, mptr);
    check($countones(gnt) <= 1, "R12 onehot", gnt, 0);
  end

  task automatic idle_cfg(logic [31:0] lo, logic [31:0] hi, logic [31:0] cfg);
    req = '0;
    repeat (2) @(negedge clk);
    slots_lo = lo; slots_hi = hi; tmo_cfg = cfg;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n3, n4;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(gnt == 0, "R1 gnt", gnt, 0);
    check(gnt_slot == 0, "R1 slot", gnt_slot, 0);
    cmp_on = 1;

    // R2/R3/R5: slot 4 -> unit 6, slot 9 -> unit 5, others null
    slots_lo = 32'h2226_2222; slots_hi = 32'h2222_2252;
    @(negedge clk);
    req = 8'h60;
    @(negedge clk);
    check(gnt == 8'h40, "R3 unit6 grant", gnt, 8'h40);
    check(gnt_slot == 4, "R2 slot4 field", gnt_slot, 4);
    req = 8'h20;
    @(negedge clk);
    check(gnt == 8'h20, "R7 handoff", gnt, 8'h20);
    check(gnt_slot == 9, "R5 next slot", gnt_slot, 9);
    req = 8'h00;
    @(negedge clk);
    check(gnt == 0, "R10 no grant", gnt, 0);
    check(gnt_slot == 9, "R10 slot kept", gnt_slot, 9);

    // R4: only null and reserved codes
    idle_cfg(32'h89AB_CDEF, 32'h2222_2222, 32'h0001_0000);
    req = 8'hFF;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(gnt == 0, "R4 skip null/reserved", gnt, 0);
    end

    // R8: timer on, preset 3
    idle_cfg(32'h2226_2222, 32'h2222_2252, 32'h0000_0003);
    req = 8'h60;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(gnt == 8'h40, "R8 held", gnt, 8'h40);
    end
    @(negedge clk);
    check(gnt == 8'h20, "R8 timeout handoff", gnt, 8'h20);

    // R9: timer off
    idle_cfg(32'h2226_2222, 32'h2222_2252, 32'h0001_0003);
    req = 8'h60;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(gnt == 8'h40, "R9 no limit", gnt, 8'h40);
    end

    // R11: unit 3 in 12 entries, unit 4 in 4 entries
    idle_cfg(32'h3333_3333, 32'h4444_3333, 32'h0000_0000);
    req = 8'h18;
    @(negedge clk);
    n3 = 0; n4 = 0;
    for (int i = 0; i < 160; i++) begin
      @(negedge clk);
      if (gnt == 8'h08) n3++;
      if (gnt == 8'h10) n4++;
    end
    check(n3 == 120, "R11 share unit3", n3, 120);
    check(n4 == 40, "R11 share unit4", n4, 40);

    // Random phase against the model
    for (int blk = 0; blk < 30; blk++) begin
      idle_cfg($urandom, $urandom, {15'd0, 1'($urandom % 2), 8'd0, 8'($urandom % 6)});
      for (int i = 0; i < 100; i++) begin
        req = 8'($urandom);
        @(negedge clk);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule